// File: doc/BRIEF.md
# Run-Time Selectable Triggered Signal Sampler

This block watches a wide bank of 32-bit probe inputs and captures four of them at a time. Each of the four output channels has its own select index, and any index may be changed while a capture is running; the change shows up in the next sample taken. Samples are taken at instants set by a rate divider. A fixed prescaler turns the system clock into a base tick, and a 5-bit rate code then picks how many base ticks lie between samples.

A capture begins on a start pulse. It can begin right away, or it can first wait for a trigger that compares channel 0 against a programmed value. It ends once a programmed number of samples has been taken, or, in endless mode, only when a stop pulse arrives. Each sample comes out as a one-cycle valid strobe together with a running sample number and the four channel values. A transport layer downstream takes the samples from these outputs.

Top module: `sig_sampler`

## Requirements
- R1: At each sample, channel k carries the 32-bit slice `probes[32*s +: 32]`, where s is the value of `sel_k` in the cycle of the sample instant. An index of `NUM_PROBES` or more yields zero. A change of index while a capture runs takes effect at the next sample.
- R2: The sample spacing is P base ticks, and a base tick occurs once every `TICK_DIV` clock cycles. P comes from `rate_code` as follows: codes 0..24 give 1,2,3,4,5,6,8,10,12,16,20,25,32,40,50,64,80,100,125,160,200,250,400,500,1000. Codes 25..31 give 1000.
- R3: With the trigger disabled, a start pulse seen in idle begins a capture. The first sample strobe appears `TICK_DIV` cycles after the clock edge that samples `start`. No strobe appears while the block is idle.
- R4: The sample number `smp_index` is 0 for the first sample of each capture and rises by one with each later sample.
- R5: When `endless` is 0, the capture ends after B*1024 samples, the last one carrying number B*1024-1. B is `count_k` clamped to the range 1..976, so 0 acts as 1. No strobe follows until the next start.
- R6: When `endless` is 1, sampling continues past the programmed count until a stop pulse arrives.
- R7: After the clock edge that samples `stop` high, no strobe appears until the next start. If `stop` and `start` are high in the same cycle, `stop` wins.
- R8: When `trig_en` is 1, a start arms the block. Sample instants at which the trigger condition fails produce no strobe. The first instant at which it holds produces sample number 0 and starts normal sampling. `trig_type` selects the condition, all compared unsigned: 0 means channel 0 > `trig_value`, 1 means channel 0 < `trig_value`, and 2 or 3 means equality.
- R9: A start pulse during an armed or running capture has no effect: the sample numbers continue without restarting.
- R10: During reset and right after it, `smp_valid` is 0 and `smp_index` and all channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| probes | input | NUM_PROBES*32 | Flattened probe bank, probe i at bits 32*i +: 32 |
| sel0 | input | SEL_W | Select index for channel 0, which is also the trigger channel |
| sel1 | input | SEL_W | Select index for channel 1 |
| sel2 | input | SEL_W | Select index for channel 2 |
| sel3 | input | SEL_W | Select index for channel 3 |
| rate_code | input | 5 | Sample rate code |
| count_k | input | 10 | Capture length in units of 1024 samples |
| endless | input | 1 | 1 = run until stop |
| trig_en | input | 1 | 1 = wait for trigger after start |
| trig_type | input | 2 | Trigger condition code |
| trig_value | input | 32 | Trigger compare value |
| start | input | 1 | One-cycle start pulse |
| stop | input | 1 | One-cycle stop pulse |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_index | output | 20 | Running sample number |
| ch0 | output | 32 | Sampled channel 0 |
| ch1 | output | 32 | Sampled channel 1 |
| ch2 | output | 32 | Sampled channel 2 |
| ch3 | output | 32 | Sampled channel 3 |

## Verification
The assertions assume that `endless` and `count_k` stay fixed for the whole of a capture. Under that assumption the sample-number limit can be checked directly against the live inputs, and the bench changes both only while the block is idle. They also assume that `start` and `stop` are single-cycle pulses, which the bench always drives through one pulse task. The select indices and the trigger value are not covered by this assumption, and the bench changes them mid-capture on purpose.

// File: rtl/sig_sampler_pkg.sv
package sig_sampler_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_RUN   = 2'd2
  } cap_state_e;

  localparam int RATE_W   = 5;
  localparam int PERIOD_W = 10;

  // base ticks between sample instants, codes past 24 clamp to the slowest
  function automatic logic [PERIOD_W-1:0] rate_period(input logic [RATE_W-1:0] code);
    case (code)
      5'd0:  return 10'd1;
      5'd1:  return 10'd2;
      5'd2:  return 10'd3;
      5'd3:  return 10'd4;
      5'd4:  return 10'd5;
      5'd5:  return 10'd6;
      5'd6:  return 10'd8;
      5'd7:  return 10'd10;
      5'd8:  return 10'd12;
      5'd9:  return 10'd16;
      5'd10: return 10'd20;
      5'd11: return 10'd25;
      5'd12: return 10'd32;
      5'd13: return 10'd40;
      5'd14: return 10'd50;
      5'd15: return 10'd64;
      5'd16: return 10'd80;
      5'd17: return 10'd100;
      5'd18: return 10'd125;
      5'd19: return 10'd160;
      5'd20: return 10'd200;
      5'd21: return 10'd250;
      5'd22: return 10'd400;
      5'd23: return 10'd500;
      default: return 10'd1000;
    endcase
  endfunction

endpackage

// File: rtl/sig_probe_sel.sv
module sig_probe_sel #(
  parameter int NUM_PROBES = 300,
  parameter int W          = 32,
  parameter int SEL_W      = $clog2(NUM_PROBES)
) (
  input  logic [NUM_PROBES*W-1:0] bank,
  input  logic [SEL_W-1:0]        sel,
  output logic [W-1:0]            value
);
  // flat AND-OR: every probe gated by its own decode, then OR-reduced
  always_comb begin
    value = '0;
    for (int i = 0; i < NUM_PROBES; i++) begin
      value = value | (bank[i*W +: W] & {W{sel == SEL_W'(i)}});
    end
  end
endmodule

// File: rtl/sig_rate_gen.sv
module sig_rate_gen
  import sig_sampler_pkg::*;
#(
  parameter int TICK_DIV = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [RATE_W-1:0] rate_code,
  output logic              strike
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0]    pre_q;
  logic [PERIOD_W-1:0] div_q;
  logic                base_tick;

  assign base_tick = (pre_q == PRE_W'(TICK_DIV - 1));
  assign strike    = active && base_tick && (div_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= base_tick ? '0 : pre_q + 1'b1;
      if (base_tick) begin
        div_q <= (div_q == '0) ? rate_period(rate_code) - 1'b1 : div_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sig_sampler.sv
module sig_sampler
  import sig_sampler_pkg::*;
#(
  parameter int NUM_PROBES = 300,
  parameter int W          = 32,
  parameter int TICK_DIV   = 50,
  parameter int STEP       = 1024,
  parameter int MAX_BLOCKS = 976,
  parameter int BLK_W      = 10,
  parameter int CNT_W      = 20,
  parameter int SEL_W      = $clog2(NUM_PROBES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PROBES*W-1:0] probes,
  input  logic [SEL_W-1:0]        sel0,
  input  logic [SEL_W-1:0]        sel1,
  input  logic [SEL_W-1:0]        sel2,
  input  logic [SEL_W-1:0]        sel3,
  input  logic [RATE_W-1:0]       rate_code,
  input  logic [BLK_W-1:0]        count_k,
  input  logic                    endless,
  input  logic                    trig_en,
  input  logic [1:0]              trig_type,
  input  logic [W-1:0]            trig_value,
  input  logic                    start,
  input  logic                    stop,
  output logic                    smp_valid,
  output logic [CNT_W-1:0]        smp_index,
  output logic [W-1:0]            ch0,
  output logic [W-1:0]            ch1,
  output logic [W-1:0]            ch2,
  output logic [W-1:0]            ch3
);
  localparam int NCH = 4;

  function automatic logic trig_match(input logic [1:0] kind, input logic [W-1:0] obs,
                                      input logic [W-1:0] ref_v);
    case (kind)
      2'd0:    return obs > ref_v;
      2'd1:    return obs < ref_v;
      default: return obs == ref_v;
    endcase
  endfunction

  function automatic logic [BLK_W-1:0] clamp_blocks(input logic [BLK_W-1:0] k);
    if (k == '0) return BLK_W'(1);
    if (k > BLK_W'(MAX_BLOCKS)) return BLK_W'(MAX_BLOCKS);
    return k;
  endfunction

  cap_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     ch_q   [NCH];
  logic [W-1:0]     picked [NCH];
  logic [SEL_W-1:0] sel_all[NCH];

  // named internal events, observed by the checker
  logic             cap_active;
  logic             cap_armed;
  logic             trig_hit;
  logic             strike;
  logic             take;
  logic [CNT_W-1:0] cap_total;
  logic             last_one;

  assign sel_all[0] = sel0;
  assign sel_all[1] = sel1;
  assign sel_all[2] = sel2;
  assign sel_all[3] = sel3;

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    sig_probe_sel #(.NUM_PROBES(NUM_PROBES), .W(W), .SEL_W(SEL_W)) u_sel (
      .bank  (probes),
      .sel   (sel_all[g]),
      .value (picked[g])
    );
  end

  sig_rate_gen #(.TICK_DIV(TICK_DIV)) u_rate (
    .clk       (clk),
    .rst       (rst),
    .active    (cap_active),
    .rate_code (rate_code),
    .strike    (strike)
  );

  assign cap_active = (st_q != CAP_IDLE);
  assign cap_armed  = (st_q == CAP_ARMED);
  assign trig_hit   = trig_match(trig_type, picked[0], trig_value);
  assign take       = strike && ((st_q == CAP_RUN) || (cap_armed && trig_hit));
  assign cap_total  = CNT_W'(clamp_blocks(count_k)) * CNT_W'(STEP);
  assign last_one   = !endless && (cnt_q == cap_total - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= CAP_IDLE;
      cnt_q     <= '0;
      smp_valid <= 1'b0;
      smp_index <= '0;
      for (int k = 0; k < NCH; k++) ch_q[k] <= '0;
    end else begin
      smp_valid <= 1'b0;
      if (stop) begin
        st_q  <= CAP_IDLE;
        cnt_q <= '0;
      end else if (st_q == CAP_IDLE) begin
        cnt_q <= '0;
        if (start) st_q <= trig_en ? CAP_ARMED : CAP_RUN;
      end else if (take) begin
        smp_valid <= 1'b1;
        smp_index <= cnt_q;
        for (int k = 0; k < NCH; k++) ch_q[k] <= picked[k];
        if (last_one) begin
          st_q  <= CAP_IDLE;
          cnt_q <= '0;
        end else begin
          st_q  <= CAP_RUN;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ch0 = ch_q[0];
  assign ch1 = ch_q[1];
  assign ch2 = ch_q[2];
  assign ch3 = ch_q[3];
endmodule

// File: rtl/sig_sampler_chk.sv
module sig_sampler_chk #(
  parameter int NUM_PROBES = 300,
  parameter int W          = 32,
  parameter int CNT_W      = 20,
  parameter int SEL_W      = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic [CNT_W-1:0] smp_index,
  input logic [W-1:0]     ch0,
  input logic [SEL_W-1:0] sel0,
  input logic             endless,
  input logic             stop,
  input logic             cap_active,
  input logic             cap_armed,
  input logic             trig_hit,
  input logic [CNT_W-1:0] cap_total
);
  logic [CNT_W-1:0] prev_idx;

  always_ff @(posedge clk) begin
    if (rst) prev_idx <= '0;
    else if (smp_valid) prev_idx <= smp_index;
  end

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    smp_valid && ($past(sel0) >= SEL_W'(NUM_PROBES)) |-> ch0 == '0); // R1
  AST_ONLY_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(cap_active)); // R3
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    smp_valid && (smp_index != '0) |-> smp_index == prev_idx + 1'b1); // R4
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    smp_valid && !$past(endless) |-> smp_index < $past(cap_total)); // R5
  AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (rst)
    $past(stop) |-> !smp_valid); // R7
  AST_ARMED_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    smp_valid && $past(cap_armed) |-> $past(trig_hit) && smp_index == '0); // R8
endmodule

bind sig_sampler sig_sampler_chk #(
  .NUM_PROBES (NUM_PROBES),
  .W          (W),
  .CNT_W      (CNT_W),
  .SEL_W      (SEL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .smp_index  (smp_index),
  .ch0        (ch0),
  .sel0       (sel0),
  .endless    (endless),
  .stop       (stop),
  .cap_active (cap_active),
  .cap_armed  (cap_armed),
  .trig_hit   (trig_hit),
  .cap_total  (cap_total)
);

// File: tb/sig_sampler_tb.sv
`timescale 1ns/1ps
module sig_sampler_tb;
  localparam int N  = 300;
  localparam int W  = 32;
  localparam int TD = 2;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N*W-1:0] probes;
  logic [SW-1:0] sel0 = '0, sel1 = '0, sel2 = '0, sel3 = '0;
  logic [4:0]    rate_code = '0;
  logic [9:0]    count_k = 10'd1;
  logic          endless = 1'b1;
  logic          trig_en = 1'b0;
  logic [1:0]    trig_type = '0;
  logic [31:0]   trig_value = '0;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic          smp_valid;
  logic [19:0]   smp_index;
  logic [31:0]   ch0, ch1, ch2, ch3;

  sig_sampler #(.NUM_PROBES(N), .W(W), .TICK_DIV(TD)) u_dut (
    .clk(clk), .rst(rst), .probes(probes),
    .sel0(sel0), .sel1(sel1), .sel2(sel2), .sel3(sel3),
    .rate_code(rate_code), .count_k(count_k), .endless(endless),
    .trig_en(trig_en), .trig_type(trig_type), .trig_value(trig_value),
    .start(start), .stop(stop),
    .smp_valid(smp_valid), .smp_index(smp_index),
    .ch0(ch0), .ch1(ch1), .ch2(ch2), .ch3(ch3)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, vcount = 0, last_idx = 0, last_gap = 0, last_vcyc = 0, start_cyc = 0;
  logic [31:0] last_ch [4];

  function automatic logic [31:0] pv(input int i);
    if (i == 3) return 32'hF000_0000;
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) probes[i*W +: W] = pv(i);
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (start) start_cyc = cyc;
    if (smp_valid) begin
      vcount++;
      last_gap  = cyc - last_vcyc;
      last_vcyc = cyc;
      last_idx  = int'(smp_index);
      last_ch[0] = ch0; last_ch[1] = ch1; last_ch[2] = ch2; last_ch[3] = ch3;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_valids(input int n);
    int target = vcount + n;
    while (vcount < target) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R10", "valid in reset", smp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "index after reset", smp_index, 0);
    chk("R10", "ch0..ch3 after reset", ch0 | ch1 | ch2 | ch3, 0);
    repeat (10) @(negedge clk);
    chk("R3", "no strobe while idle", vcount, 0);
  endtask

  task automatic t_select();
    sel0 = SW'(5); sel1 = SW'(299); sel2 = SW'(0); sel3 = SW'(300);
    endless = 1'b1; rate_code = 5'd0; trig_en = 1'b0;
    pulse_start();
    wait_valids(1);
    chk("R3", "first strobe delay", last_vcyc - start_cyc, TD);
    chk("R4", "first index", last_idx, 0);
    chk("R1", "ch0 = probe 5", last_ch[0], pv(5));
    chk("R1", "ch1 = probe 299", last_ch[1], pv(299));
    chk("R1", "ch2 = probe 0", last_ch[2], pv(0));
    chk("R1", "ch3 out of range is zero", last_ch[3], 0);
    sel0 = SW'(17); sel3 = SW'(42);
    wait_valids(2);
    chk("R1", "ch0 after live reselect", last_ch[0], pv(17));
    chk("R1", "ch3 after live reselect", last_ch[3], pv(42));
    chk("R4", "index increments", last_idx, 2);
    chk("R2", "code 0 spacing", last_gap, 1 * TD);
    pulse_stop();
  endtask

  task automatic t_rate(input logic [4:0] code, input int period);
    rate_code = code;
    pulse_start();
    wait_valids(3);
    chk("R2", $sformatf("spacing for code %0d", code), last_gap, period * TD);
    pulse_stop();
  endtask

  task automatic t_count(input logic [9:0] k);
    int base;
    endless = 1'b0; count_k = k; rate_code = 5'd0;
    base = vcount;
    pulse_start();
    wait_valids(1024);
    repeat (60) @(negedge clk);
    chk("R5", $sformatf("samples for count_k %0d", k), vcount - base, 1024);
    chk("R5", "last sample number", last_idx, 1023);
    endless = 1'b1;
  endtask

  task automatic t_endless();
    int base;
    endless = 1'b1; count_k = 10'd1; rate_code = 5'd0;
    pulse_start();
    wait_valids(1100);
    chk("R6", "runs past count", last_idx, 1099);
    pulse_start();                        // ignored while running
    base = last_idx;
    wait_valids(2);
    chk("R9", "start ignored mid-capture", last_idx, base + 2);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    base = vcount;
    repeat (20) @(negedge clk);
    chk("R7", "no strobe after stop", vcount - base, 0);
    @(negedge clk); start = 1'b1; stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7", "stop beats start", vcount - base, 0);
  endtask

  task automatic t_trig(input logic [1:0] kind, input logic [31:0] val, input bit expect_hit,
                        input string what);
    int base;
    sel0 = SW'(3); trig_en = 1'b1; trig_type = kind; trig_value = val; rate_code = 5'd1;
    base = vcount;
    pulse_start();
    repeat (30) @(negedge clk);
    if (expect_hit) begin
      chk("R8", {what, " fires"}, (vcount - base) > 0, 1);
      chk("R8", {what, " first index"}, (vcount - base) == 0 ? -1 : 0, 0);
    end else begin
      chk("R8", {what, " holds off"}, vcount - base, 0);
    end
    pulse_stop();
    trig_en = 1'b0;
  endtask

  task automatic t_trig_late();
    int base;
    sel0 = SW'(3); trig_en = 1'b1; trig_type = 2'd0; trig_value = 32'hF000_0000; rate_code = 5'd0;
    base = vcount;
    pulse_start();
    repeat (40) @(negedge clk);
    chk("R8", "armed, no strobe", vcount - base, 0);
    trig_value = 32'hEFFF_FFFF;
    wait_valids(1);
    chk("R8", "late hit gives index 0", last_idx, 0);
    chk("R8", "late hit carries ch0", last_ch[0], 32'hF000_0000);
    wait_valids(1);
    chk("R4", "continues after trigger", last_idx, 1);
    pulse_stop();
    trig_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_select();
    t_rate(5'd5, 6);
    t_rate(5'd13, 40);
    t_rate(5'd24, 1000);
    t_rate(5'd31, 1000);
    t_count(10'd1);
    t_count(10'd0);
    t_endless();
    t_trig(2'd0, 32'h0000_0001, 1'b1, "above, unsigned");
    t_trig(2'd0, 32'hF000_0000, 1'b0, "above, equal value");
    t_trig(2'd1, 32'hF000_0001, 1'b1, "below");
    t_trig(2'd1, 32'hF000_0000, 1'b0, "below, equal value");
    t_trig(2'd2, 32'hF000_0000, 1'b1, "equal");
    t_trig(2'd3, 32'h0000_0005, 1'b0, "equal alt, mismatch");
    t_trig_late();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule